// File: doc/BRIEF.md
# I2C Byte Master with Arbitration Hand-off

This block drives an I2C bus as a master, one byte or one bus condition per host command. The host asks for a START, a byte write, a byte read that ends in ACK or NACK, a repeated START or a STOP. Each command is accepted when `cmd_ready` is high and is closed by a one-cycle `done` pulse. Both bus lines are open-drain. The block pulls a line low by raising its output enable and reads the wired level back on the matching input. Both inputs are assumed to be already synchronised to `clk`.

Before it drives anything, a START request waits until the bus is free. The bus is free when no START is pending without a matching STOP and both lines are high for a full SCL low period. This keeps a transfer that another master already started from being disturbed. While writing, the block may release SDA for a 1 and then see SDA low with SCL high. It then drops both lines in the next cycle and raises a sticky lost flag. In the same cycle it hands the bits seen on the bus so far to neighbouring slave logic, so that logic can continue matching its own address within the same transfer.

SCL low and high phases each last `div_cfg + 1` clock cycles. The high phase only starts counting once the SCL input actually reads high, so a device that holds SCL low simply stalls the block.

Top module: `i2c_arb_master`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are 0, `cmd_ready` is 1, and `arb_lost`, `master_active` and `bus_busy` are 0.
- R2: `bus_busy` rises after SDA falls while SCL is high, and clears after SDA rises while SCL is high. A START command (`cmd_op` = 1) drives no line while `bus_busy` is 1. It stays unfinished with `cmd_ready` low until the bus is free.
- R3: When a START completes, `master_active` and `bus_busy` are 1 and SCL is held low. When a STOP command (`cmd_op` = 4) completes, both lines are released and `master_active` and `bus_busy` are 0.
- R4: A write command (`cmd_op` = 2) places the eight bits of `cmd_data` on SDA, most significant bit first. Each bit is stable for the whole time SCL is high.
- R5: On the ninth clock of a write, the block releases SDA. `rx_ack` reports the level seen there: 0 means the receiver acknowledged.
- R6: A read command (`cmd_op` = 3) leaves SDA released for eight clocks and returns the sampled byte, first bit as MSB, on `rx_data`. On the ninth clock it pulls SDA low when `cmd_data[0]` is 0 (ACK) and leaves SDA released when it is 1 (NACK).
- R7: A repeated START (`cmd_op` = 5, or START while already master) produces a new START with no STOP in between. `bus_busy` and `master_active` stay 1 throughout.
- R8: The block releases SCL and waits for the SCL input to read high. It pulls SCL low again on the (`div_cfg`+1)-th rising clock edge that finds SCL high. While another device holds SCL low, the block does not advance.
- R9: During the eight data bits of a write, a released SDA read low with SCL high is a loss. In the following cycle `scl_oe`, `sda_oe` and `master_active` are 0, `arb_lost` is 1, and `slv_take` pulses. `slv_byte` then holds the bus bits of this byte seen so far, with the most recent bit in bit 0, including the losing bit as 0. `slv_bits` gives their count.
- R10: While not master, WRITE, READ, STOP and repeated START, like codes 0, 6 and 7, are finished in the accepting cycle with no line driven. `arb_lost` stays set until the next accepted command of any kind, which clears it.
- R11: `cmd_ready` is low from the cycle after a command that starts bus activity is accepted until its `done` pulse. `done` only occurs while `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_cfg | input | DIV_W | SCL phase length minus one, in clock cycles |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code: 1 START, 2 WRITE, 3 READ, 4 STOP, 5 repeated START |
| cmd_data | input | DATA_W | Byte to write; bit 0 selects NACK for a read |
| cmd_ready | output | 1 | Block can accept a command |
| done | output | 1 | One-cycle pulse when a command finishes |
| rx_data | output | DATA_W | Byte returned by the last read |
| rx_ack | output | 1 | SDA level on the ninth clock of the last byte |
| arb_lost | output | 1 | Sticky arbitration-loss flag |
| master_active | output | 1 | Block currently owns the bus |
| bus_busy | output | 1 | A START has been seen without a following STOP |
| slv_take | output | 1 | One-cycle hand-off pulse on loss |
| slv_byte | output | DATA_W | Bus bits of the interrupted byte |
| slv_bits | output | BIT_W | Number of valid bits in `slv_byte` |
| scl_i | input | 1 | Wired SCL level |
| sda_i | input | 1 | Wired SDA level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
Faults in the bit sequencer show up on the bus within a single SCL phase. A wrong bit index or shift register puts a mis-ordered byte on SDA, or returns a wrong `rx_data` at the `done` pulse of that same byte. Bad ownership or loss state surfaces in the next cycle as a line that is still enabled after `slv_take`, or as a line driven while `master_active` is 0. A counter that ignores the SCL readback shortens the measured high phase on the first stretched bit. A faulty bus monitor drives lines during a foreign transfer within `div_cfg`+1 cycles of the request.

// File: rtl/i2c_arb_pkg.sv
`timescale 1ns/1ps
package i2c_arb_pkg;

    // Host command codes
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_START  = 3'd1,
        OP_WRITE  = 3'd2,
        OP_READ   = 3'd3,
        OP_STOP   = 3'd4,
        OP_RSTART = 3'd5
    } op_e;

    // Sequencer states
    typedef enum logic [3:0] {
        S_IDLE,
        S_FREE,
        S_STA_SDA,
        S_STA_SCL,
        S_BIT_LOW,
        S_BIT_HIGH,
        S_RS_LOW,
        S_RS_HIGH,
        S_STO_LOW,
        S_STO_HIGH,
        S_STO_REL
    } st_e;

endpackage

// File: rtl/i2c_arb_busmon.sv
`timescale 1ns/1ps
// Watches the wired lines for START and STOP conditions and keeps a busy flag.
module i2c_arb_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic busy
);
    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
        logic busy;
    } mon_t;

    mon_t q, d;

    always_comb begin
        d = q;
        d.scl_prev = scl_i;
        d.sda_prev = sda_i;
        if (q.scl_prev && scl_i) begin
            if (q.sda_prev && !sda_i) begin
                d.busy = 1'b1;
            end else if (!q.sda_prev && sda_i) begin
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl_prev: 1'b1, sda_prev: 1'b1, busy: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy = q.busy;
endmodule

// File: rtl/i2c_arb_phase.sv
`timescale 1ns/1ps
// Down-counter that times one SCL phase; reloads whenever load is high.
module i2c_arb_phase #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] div,
    output logic         expired
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = div;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/i2c_arb_master.sv
`timescale 1ns/1ps
module i2c_arb_master
    import i2c_arb_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 8,
    localparam int BIT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              cmd_ready,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ack,
    output logic              arb_lost,
    output logic              master_active,
    output logic              bus_busy,
    output logic              slv_take,
    output logic [DATA_W-1:0] slv_byte,
    output logic [BIT_W-1:0]  slv_bits,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W);

    typedef struct packed {
        st_e               st;
        logic              own;
        logic              scl_drv;
        logic              sda_drv;
        logic              rd;
        logic              nack;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rx;
        logic              ack;
        logic              lost;
        logic              done;
        logic              take;
        logic [DATA_W-1:0] tbyte;
        logic [BIT_W-1:0]  tbits;
    } regs_t;

    regs_t q, d;
    logic  load;
    logic  expired;
    logic  busy;

    i2c_arb_busmon u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .busy  (busy)
    );

    i2c_arb_phase #(.W(DIV_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .div     (div_cfg),
        .expired (expired)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.take = 1'b0;
        load   = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    d.lost = 1'b0;
                    load   = 1'b1;
                    case (cmd_op)
                        OP_START, OP_RSTART: begin
                            if (q.own) begin
                                d.st = S_RS_LOW;
                            end else if (cmd_op == OP_START) begin
                                d.st = S_FREE;
                            end else begin
                                d.done = 1'b1;
                            end
                        end
                        OP_WRITE, OP_READ: begin
                            if (q.own) begin
                                d.st   = S_BIT_LOW;
                                d.rd   = (cmd_op == OP_READ);
                                d.nack = cmd_data[0];
                                d.tx   = cmd_data;
                                d.sh   = '0;
                                d.bitn = '0;
                            end else begin
                                d.done = 1'b1;
                            end
                        end
                        OP_STOP: begin
                            if (q.own) begin
                                d.st = S_STO_LOW;
                            end else begin
                                d.done = 1'b1;
                            end
                        end
                        default: d.done = 1'b1;
                    endcase
                end
            end
            S_FREE: begin
                // bus must stay idle with both lines high for a whole phase
                if (busy || !scl_i || !sda_i) begin
                    load = 1'b1;
                end else if (expired) begin
                    d.sda_drv = 1'b1;
                    d.own     = 1'b1;
                    d.st      = S_STA_SDA;
                    load      = 1'b1;
                end
            end
            S_STA_SDA: begin
                if (expired) begin
                    d.scl_drv = 1'b1;
                    d.st      = S_STA_SCL;
                    load      = 1'b1;
                end
            end
            S_STA_SCL: begin
                if (expired) begin
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            S_RS_LOW: begin
                d.sda_drv = 1'b0;
                if (expired) begin
                    d.scl_drv = 1'b0;
                    d.st      = S_RS_HIGH;
                    load      = 1'b1;
                end
            end
            S_RS_HIGH: begin
                if (!scl_i) begin
                    load = 1'b1;
                end else if (expired) begin
                    d.sda_drv = 1'b1;
                    d.st      = S_STA_SDA;
                    load      = 1'b1;
                end
            end
            S_BIT_LOW: begin
                // data changes one cycle after SCL went low
                if (q.bitn == LAST_BIT) begin
                    d.sda_drv = q.rd && !q.nack;
                end else begin
                    d.sda_drv = !q.rd && !q.tx[DATA_W-1];
                end
                if (expired) begin
                    d.scl_drv = 1'b0;
                    d.st      = S_BIT_HIGH;
                    load      = 1'b1;
                end
            end
            S_BIT_HIGH: begin
                if (!scl_i) begin
                    load = 1'b1;
                end else if (!q.rd && (q.bitn != LAST_BIT) && !q.sda_drv && !sda_i) begin
                    d.own     = 1'b0;
                    d.scl_drv = 1'b0;
                    d.sda_drv = 1'b0;
                    d.lost    = 1'b1;
                    d.take    = 1'b1;
                    d.done    = 1'b1;
                    d.tbyte   = {q.sh[DATA_W-2:0], 1'b0};
                    d.tbits   = q.bitn + 1'b1;
                    d.st      = S_IDLE;
                end else if (expired) begin
                    d.scl_drv = 1'b1;
                    if (q.bitn == LAST_BIT) begin
                        d.ack  = sda_i;
                        d.rx   = q.sh;
                        d.done = 1'b1;
                        d.st   = S_IDLE;
                    end else begin
                        d.sh   = {q.sh[DATA_W-2:0], sda_i};
                        d.tx   = {q.tx[DATA_W-2:0], 1'b0};
                        d.bitn = q.bitn + 1'b1;
                        d.st   = S_BIT_LOW;
                        load   = 1'b1;
                    end
                end
            end
            S_STO_LOW: begin
                d.sda_drv = 1'b1;
                if (expired) begin
                    d.scl_drv = 1'b0;
                    d.st      = S_STO_HIGH;
                    load      = 1'b1;
                end
            end
            S_STO_HIGH: begin
                if (!scl_i) begin
                    load = 1'b1;
                end else if (expired) begin
                    d.sda_drv = 1'b0;
                    d.st      = S_STO_REL;
                    load      = 1'b1;
                end
            end
            S_STO_REL: begin
                if (expired) begin
                    d.own  = 1'b0;
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready     = (q.st == S_IDLE);
    assign done          = q.done;
    assign rx_data       = q.rx;
    assign rx_ack        = q.ack;
    assign arb_lost      = q.lost;
    assign master_active = q.own;
    assign bus_busy      = busy;
    assign slv_take      = q.take;
    assign slv_byte      = q.tbyte;
    assign slv_bits      = q.tbits;
    assign scl_oe        = q.scl_drv;
    assign sda_oe        = q.sda_drv;
endmodule

// File: rtl/i2c_arb_master_chk.sv
`timescale 1ns/1ps
module i2c_arb_master_chk #(
    parameter int DATA_W = 8,
    parameter int BIT_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             done,
    input logic             arb_lost,
    input logic             master_active,
    input logic             bus_busy,
    input logic             slv_take,
    input logic [BIT_W-1:0] slv_bits,
    input logic             scl_oe,
    input logic             sda_oe
);
    AST_SCL_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> master_active); // R10
    AST_SDA_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> master_active); // R10
    AST_SCL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> bus_busy); // R2
    AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready); // R11
    AST_TAKE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        slv_take |-> (!scl_oe && !sda_oe && arb_lost && !master_active)); // R9
    AST_TAKE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        slv_take |-> (slv_bits != '0 && slv_bits <= BIT_W'(DATA_W))); // R9
    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !(cmd_valid && cmd_ready)) |=> arb_lost); // R10
endmodule

bind i2c_arb_master i2c_arb_master_chk #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .done          (done),
    .arb_lost      (arb_lost),
    .master_active (master_active),
    .bus_busy      (bus_busy),
    .slv_take      (slv_take),
    .slv_bits      (slv_bits),
    .scl_oe        (scl_oe),
    .sda_oe        (sda_oe)
);

// File: tb/i2c_arb_master_bench.sv
`timescale 1ns/1ps
module i2c_arb_master_bench;
    localparam int DIV_W  = 8;
    localparam int DATA_W = 8;
    localparam int BIT_W  = 4;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] data;
        logic       sack;   // bench slave pulls the ninth bit low
        logic [7:0] srd;    // byte the bench slave returns on a read
        logic       eack;   // expected rx_ack after a write
        logic       eown;
        logic       ebusy;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},
        '{3'd2, 8'hA4, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1},
        '{3'd2, 8'h5B, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1},
        '{3'd5, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},
        '{3'd2, 8'hA5, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1},
        '{3'd3, 8'h00, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b1},
        '{3'd3, 8'h01, 1'b0, 8'hC3, 1'b0, 1'b1, 1'b1},
        '{3'd4, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  div_cfg = 8'd3;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = 3'd0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic              cmd_ready, done, rx_ack, arb_lost, master_active, bus_busy, slv_take;
    logic [DATA_W-1:0] rx_data, slv_byte;
    logic [BIT_W-1:0]  slv_bits;
    logic              scl_oe, sda_oe;
    logic              ext_scl_low = 1'b0;
    logic              ext_sda_low = 1'b0;
    logic              scl_line, sda_line;

    assign scl_line = ~scl_oe & ~ext_scl_low;
    assign sda_line = ~sda_oe & ~ext_sda_low;

    int   n_checks = 0;
    int   n_errors = 0;
    logic [7:0] cap_byte;
    logic       mack;
    logic       ready_after;

    always #2 clk = ~clk;

    i2c_arb_master #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_i2c_arb_master (
        .clk (clk), .rst_n (rst_n), .div_cfg (div_cfg),
        .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_data (cmd_data),
        .cmd_ready (cmd_ready), .done (done), .rx_data (rx_data), .rx_ack (rx_ack),
        .arb_lost (arb_lost), .master_active (master_active), .bus_busy (bus_busy),
        .slv_take (slv_take), .slv_byte (slv_byte), .slv_bits (slv_bits),
        .scl_i (scl_line), .sda_i (sda_line), .scl_oe (scl_oe), .sda_oe (sda_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, "R11 done timeout", {31'd0, done}, 32'd1);
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [7:0] dat);
        int n = 0;
        while (!cmd_ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = dat;
        @(negedge clk);
        cmd_valid   = 1'b0;
        ready_after = cmd_ready;
        wait_done();
    endtask

    task automatic slave_write(input logic ack_low);
        cap_byte = '0;
        for (int i = 0; i < 8; i++) begin
            @(posedge scl_line);
            cap_byte = {cap_byte[6:0], sda_line};
        end
        @(negedge scl_line);
        ext_sda_low = ack_low;
        @(negedge scl_line);
        ext_sda_low = 1'b0;
    endtask

    task automatic slave_read(input logic [7:0] b);
        ext_sda_low = ~b[7];
        for (int i = 6; i >= 0; i--) begin
            @(negedge scl_line);
            ext_sda_low = ~b[i];
        end
        @(negedge scl_line);
        ext_sda_low = 1'b0;
        @(posedge scl_line);
        mack = sda_line;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(scl_oe == 0 && sda_oe == 0, "R1 lines released", {30'd0, scl_oe, sda_oe}, 0);
        check(cmd_ready == 1, "R1 ready", {31'd0, cmd_ready}, 1);
        check(arb_lost == 0, "R1 lost clear", {31'd0, arb_lost}, 0);
        check(master_active == 0 && bus_busy == 0, "R1 idle bus", {30'd0, master_active, bus_busy}, 0);

        // R2: foreign START makes the bus busy; our START is held off
        ext_sda_low = 1'b1;
        repeat (3) @(negedge clk);
        check(bus_busy == 1, "R2 busy after foreign start", {31'd0, bus_busy}, 1);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_data = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (100) @(negedge clk);
        check(scl_oe == 0 && sda_oe == 0, "R2 no drive while busy", {30'd0, scl_oe, sda_oe}, 0);
        check(cmd_ready == 0 && done == 0, "R2 start pending", {30'd0, cmd_ready, done}, 0);
        ext_sda_low = 1'b0;   // foreign STOP
        wait_done();
        check(master_active == 1 && bus_busy == 1, "R3 owned after start", {30'd0, master_active, bus_busy}, 3);
        do_cmd(3'd4, 8'h00);
        check(master_active == 0 && bus_busy == 0, "R3 released after stop", {30'd0, master_active, bus_busy}, 0);

        // table of bus transactions
        for (int v = 0; v < 8; v++) begin
            vec_t t = VECS[v];
            mack = 1'bx;
            fork
                do_cmd(t.op, t.data);
                begin
                    if (t.op == 3'd2) slave_write(t.sack);
                    else if (t.op == 3'd3) slave_read(t.srd);
                end
            join
            check(ready_after == 0, "R11 ready low while running", {31'd0, ready_after}, 0);
            if (t.op == 3'd2) begin
                check(cap_byte == t.data, "R4 byte on bus", {24'd0, cap_byte}, {24'd0, t.data});
                check(rx_ack == t.eack, "R5 ninth bit", {31'd0, rx_ack}, {31'd0, t.eack});
            end else if (t.op == 3'd3) begin
                check(rx_data == t.srd, "R6 read byte", {24'd0, rx_data}, {24'd0, t.srd});
                check(mack === t.data[0], "R6 master ack level", {31'd0, mack}, {31'd0, t.data[0]});
            end
            if (t.op == 3'd5)
                check(master_active == t.eown && bus_busy == t.ebusy, "R7 repeated start keeps bus",
                      {30'd0, master_active, bus_busy}, {30'd0, t.eown, t.ebusy});
            else
                check(master_active == t.eown && bus_busy == t.ebusy, "R3 ownership",
                      {30'd0, master_active, bus_busy}, {30'd0, t.eown, t.ebusy});
        end

        // R8: stretched SCL, high phase counted from readback
        div_cfg = 8'd5;
        do_cmd(3'd1, 8'h00);
        ext_scl_low = 1'b1;
        fork
            do_cmd(3'd2, 8'h81);
            begin
                int hi = 0;
                repeat (40) @(negedge clk);
                check(scl_oe == 0 && done == 0, "R8 stall while held low", {30'd0, scl_oe, done}, 0);
                ext_scl_low = 1'b0;
                @(negedge clk);
                while (scl_line) begin
                    hi++;
                    @(negedge clk);
                end
                // released before edge 1, pulled low on edge div+1: div samples high
                check(hi == 5, "R8 high length", hi, 5);
            end
        join
        do_cmd(3'd4, 8'h00);
        div_cfg = 8'd3;

        // R9: arbitration loss at bit 2 of 0xB0 against 0x90 from another master
        do_cmd(3'd1, 8'h00);
        fork
            do_cmd(3'd2, 8'hB0);
            begin
                @(negedge scl_line);
                ext_sda_low = 1'b1;
            end
        join
        check(slv_take == 1, "R9 hand-off pulse", {31'd0, slv_take}, 1);
        check(slv_byte == 8'h04, "R9 partial byte", {24'd0, slv_byte}, 32'h04);
        check(slv_bits == 4'd3, "R9 bit count", {28'd0, slv_bits}, 3);
        check(scl_oe == 0 && sda_oe == 0, "R9 lines dropped", {30'd0, scl_oe, sda_oe}, 0);
        check(arb_lost == 1 && master_active == 0, "R9 lost flag", {30'd0, arb_lost, master_active}, 2);
        ext_sda_low = 1'b0;
        repeat (20) @(negedge clk);
        check(arb_lost == 1, "R10 lost sticky", {31'd0, arb_lost}, 1);

        // R10: write while not master is dropped and clears the flag
        do_cmd(3'd2, 8'h00);
        check(ready_after == 1, "R10 dropped at once", {31'd0, ready_after}, 1);
        check(scl_oe == 0 && sda_oe == 0, "R10 no drive", {30'd0, scl_oe, sda_oe}, 0);
        check(arb_lost == 0, "R10 flag cleared", {31'd0, arb_lost}, 0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule